// File: doc/BRIEF.md
# Analog Setpoint Refresh Sequencer

This block keeps a bank of 32 external sample-and-hold capacitors topped up from a single DAC, without any help from the host once set up. Each channel has an 8-bit setpoint code. The codes are kept in a 128-word by 8-bit memory. Only the first 32 words take part in refresh.

The block has two modes. In load mode the host places codes into the memory, one address and data pair at a time. In refresh mode a free-running channel counter advances at a fixed step rate. From that one counter the block derives four things: the memory word to read, the DAC code, the analog multiplexer select and a one-hot hold strobe. The strobe comes from a bank of 4-to-16 decoders.

The host steers the counter through a three-bit control word: output enable, count enable and synchronous clear. The counter wraps after the last channel, so refresh continues for as long as it is enabled. The step period is a parameter: one refresh step per `STEP_DIV` system clocks (500 Hz from a 125 MHz clock by default).

Top module: `setpoint_refresher`

## Requirements
- R1: After a synchronous reset, `hold_strobe`, `dac_code` and `mux_sel` are all zero, and the control word is cleared (refresh stopped, outputs disabled).
- R2: While control bit 1 (count enable) is 0, a pulse on `host_wr` stores `host_data` at `host_addr` in the 128-entry code memory. Channel n is refreshed from address n (0..31), and addresses 32..127 never reach the DAC.
- R3: A `host_wr` pulse while count enable is 1 is discarded. The stored code is unchanged at the next refresh of that channel.
- R4: Writing the control word with bit 2 (clear) set returns the channel counter to 0 and restarts the step timer. The bit is not stored.
- R5: While count enable is 1, the channel counter advances once every `STEP_DIV` clocks, and it wraps from 31 to 0.
- R6: `dac_code` presents the stored code of the current channel and `mux_sel` its channel number. Both change two clocks after the channel counter steps.
- R7: `hold_strobe` has at most one bit set, and that bit's index equals `mux_sel`. Bits 0..15 come from the lower decoder and bits 16..31 from the upper one, selected by channel bit 4.
- R8: The strobe rises only after `dac_code` has held for one full clock, and it falls on the edge where `dac_code` changes. In steady refresh each pulse lasts `STEP_DIV-1` clocks, with one idle clock between pulses. The first pulse after enabling from a cleared counter lasts `STEP_DIV+1` clocks.
- R9: When control bit 0 (output enable) or count enable is 0, `hold_strobe` is all zero from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 7 | Memory address for a host code write |
| host_data | input | 8 | Code value for a host write |
| host_wr | input | 1 | Host code write strobe (honoured in load mode only) |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 3 | Control word: bit0 output enable, bit1 count enable, bit2 clear |
| dac_code | output | 8 | Code driven to the DAC |
| mux_sel | output | 5 | Analog multiplexer select (channel number) |
| hold_strobe | output | 32 | One-hot sample-and-hold strobe |

## Verification
Three latencies are observable at the ports:
- A channel step reaches `dac_code` and `mux_sel` two clocks after the counter moves.
- The strobe follows one clock later still.
- Gating by the control word takes effect on the next clock.

The bench does not count cycles from the host writes. Instead, it samples on falling edges and detects each strobe pulse as it starts. At that moment it compares the strobe index, `mux_sel` and `dac_code` against the next scoreboard entry. When the pulse ends, it compares the measured width against the entry's expected width: `STEP_DIV+1` for the first pulse after enabling, and `STEP_DIV-1` for every other pulse. Quiet periods under each gating condition are checked clock by clock for an all-zero strobe.

// File: rtl/srf_pkg.sv
package srf_pkg;
  // Control word bit positions (host-visible encoding).
  localparam int CTL_OUT_EN = 0;
  localparam int CTL_RUN    = 1;
  localparam int CTL_CLR    = 2;
  localparam int CTL_W      = 3;

  typedef struct packed {
    logic run;
    logic out_en;
  } ctrl_t;
endpackage

// File: rtl/srf_step_timer.sv
module srf_step_timer #(
  parameter int STEP_DIV = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int DIV_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(STEP_DIV - 1);

  logic [DIV_W-1:0] div_q;

  assign tick = run && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (run) begin
      if (div_q == LAST) div_q <= '0;
      else               div_q <= div_q + 1'b1;
    end
  end

  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/srf_chan_counter.sv
module srf_chan_counter #(
  parameter int CHANNELS = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic                        tick,
  output logic [$clog2(CHANNELS)-1:0] ch_q
);
  localparam int CH_W = $clog2(CHANNELS);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(CHANNELS - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ch_q <= '0;
    end else if (tick) begin
      if (ch_q == LAST_CH) ch_q <= '0;
      else                 ch_q <= ch_q + 1'b1;
    end
  end

  // R5
  chan_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && ch_q == LAST_CH) |=> (ch_q == '0));
  // R5
  chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(ch_q));
endmodule

// File: rtl/srf_code_mem.sv
module srf_code_mem #(
  parameter int DEPTH  = 128,
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [CODE_W-1:0]        wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [CODE_W-1:0]        rdata
);
  logic [CODE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/srf_strobe_decoder.sv
module srf_strobe_decoder #(
  parameter int CHANNELS = 32,
  parameter int DEC_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic [$clog2(CHANNELS)-1:0] ch,
  output logic [CHANNELS-1:0]         strobe
);
  localparam int CH_W     = $clog2(CHANNELS);
  localparam int DEC_OUTS = 1 << DEC_W;
  localparam int BANKS    = (CHANNELS + DEC_OUTS - 1) / DEC_OUTS;

  logic [BANKS*DEC_OUTS-1:0] dec_all;
  logic [CH_W-1:0]           bank_idx;
  logic [DEC_OUTS-1:0]       one_bit;

  assign bank_idx = ch >> DEC_W;
  assign one_bit  = DEC_OUTS'(1);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic bank_en;
    assign bank_en = (bank_idx == CH_W'(b));
    assign dec_all[b*DEC_OUTS +: DEC_OUTS] =
      bank_en ? (one_bit << ch[DEC_W-1:0]) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)     strobe <= '0;
    else if (en) strobe <= dec_all[CHANNELS-1:0];
    else         strobe <= '0;
  end

  // R7
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));
endmodule

// File: rtl/setpoint_refresher.sv
module setpoint_refresher #(
  parameter int CHANNELS  = 32,
  parameter int CODE_W    = 8,
  parameter int MEM_DEPTH = 128,
  parameter int DEC_W     = 4,
  parameter int STEP_DIV  = 250000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [$clog2(MEM_DEPTH)-1:0] host_addr,
  input  logic [CODE_W-1:0]            host_data,
  input  logic                         host_wr,
  input  logic                         ctrl_we,
  input  logic [2:0]                   ctrl_wdata,
  output logic [CODE_W-1:0]            dac_code,
  output logic [$clog2(CHANNELS)-1:0]  mux_sel,
  output logic [CHANNELS-1:0]          hold_strobe
);
  import srf_pkg::*;

  localparam int CH_W   = $clog2(CHANNELS);
  localparam int ADDR_W = $clog2(MEM_DEPTH);

  ctrl_t             ctrl_q;
  logic              clr;
  logic              tick;
  logic              mem_we;
  logic [CH_W-1:0]   ch_q;
  logic [CH_W-1:0]   ch_d1;
  logic [CODE_W-1:0] rd_code;
  logic              strobe_en;

  assign clr = ctrl_we && ctrl_wdata[CTL_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q.run    <= ctrl_wdata[CTL_RUN];
      ctrl_q.out_en <= ctrl_wdata[CTL_OUT_EN];
    end
  end

  srf_step_timer #(.STEP_DIV(STEP_DIV)) u_timer (
    .clk(clk), .rst(rst), .clr(clr), .run(ctrl_q.run), .tick(tick)
  );

  srf_chan_counter #(.CHANNELS(CHANNELS)) u_counter (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick), .ch_q(ch_q)
  );

  assign mem_we = host_wr && !ctrl_q.run;

  srf_code_mem #(.DEPTH(MEM_DEPTH), .CODE_W(CODE_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(host_addr), .wdata(host_data),
    .raddr(ADDR_W'(ch_q)), .rdata(rd_code)
  );

  // Align channel number with the memory read latency, then register outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      ch_d1    <= '0;
      mux_sel  <= '0;
      dac_code <= '0;
    end else begin
      ch_d1    <= ch_q;
      mux_sel  <= ch_d1;
      dac_code <= rd_code;
    end
  end

  // Strobe only once the output code has settled for a clock.
  assign strobe_en = ctrl_q.out_en && ctrl_q.run && (ch_d1 == mux_sel);

  srf_strobe_decoder #(.CHANNELS(CHANNELS), .DEC_W(DEC_W)) u_dec (
    .clk(clk), .rst(rst), .en(strobe_en), .ch(mux_sel), .strobe(hold_strobe)
  );

  // R8
  code_settled_chk: assert property (@(posedge clk) disable iff (rst)
    (|hold_strobe) |-> $stable(dac_code));
  // R7
  strobe_matches_mux_chk: assert property (@(posedge clk) disable iff (rst)
    (|hold_strobe) |-> hold_strobe[mux_sel]);
  // R9
  gated_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.out_en || !ctrl_q.run) |=> (hold_strobe == '0));

  initial begin
    assert (STEP_DIV >= 3) else $error("STEP_DIV must be at least 3");
  end
endmodule

// File: tb/setpoint_refresher_bench.sv
module setpoint_refresher_bench;
  localparam int D  = 6;
  localparam int NC = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] host_addr = '0;
  logic [7:0] host_data = '0;
  logic       host_wr = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [2:0] ctrl_wdata = '0;
  logic [7:0] dac_code;
  logic [4:0] mux_sel;
  logic [31:0] hold_strobe;

  always #4 clk = ~clk;

  setpoint_refresher #(.STEP_DIV(D)) u_setpoint_refresher (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_data(host_data),
    .host_wr(host_wr), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .dac_code(dac_code), .mux_sel(mux_sel), .hold_strobe(hold_strobe)
  );

  typedef struct {
    int ch;
    int code;
    int len;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int pulses_done = 0;
  int model [NC];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mem_write(input int a, input int d);
    @(negedge clk);
    host_addr = 7'(a); host_data = 8'(d); host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic ctrl_write(input logic [2:0] w);
    @(negedge clk);
    ctrl_wdata = w; ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic push_item(input int ch, input int len);
    item_t it;
    it.ch = ch; it.code = model[ch]; it.len = len;
    q.push_back(it);
  endtask

  task automatic expect_quiet(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(hold_strobe == '0, req, int'(hold_strobe), 0);
    end
  endtask

  function automatic int onehot_idx(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  // Monitor: pulse start compares identity and code, pulse end compares width.
  logic [31:0] prev_strobe = '0;
  bit          active = 0;
  item_t       cur;
  int          cur_len = 0;
  logic [7:0]  cur_code = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_strobe != 0 && hold_strobe != prev_strobe && active) begin
        // R8: width of the pulse
        chk(cur_len == cur.len, "R8 width", cur_len, cur.len);
        active = 0;
        pulses_done++;
      end
      if (hold_strobe != 0 && hold_strobe != prev_strobe) begin
        if (q.size() > 0) begin
          cur = q.pop_front();
          active = 1;
          cur_len = 1;
          cur_code = dac_code;
          // R7: one-hot index follows the channel counter order (R5)
          chk($countones(hold_strobe) == 1 && onehot_idx(hold_strobe) == cur.ch,
              "R7 strobe index", onehot_idx(hold_strobe), cur.ch);
          // R6: mux select and code
          chk(int'(mux_sel) == cur.ch, "R6 mux_sel", int'(mux_sel), cur.ch);
          chk(int'(dac_code) == cur.code, "R6 dac_code", int'(dac_code), cur.code);
        end
      end else if (hold_strobe != 0 && active) begin
        cur_len++;
        if (dac_code != cur_code)
          chk(0, "R8 code held under strobe", int'(dac_code), int'(cur_code));
      end
      prev_strobe = hold_strobe;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(hold_strobe == '0, "R1 strobe", int'(hold_strobe), 0);
    chk(dac_code == '0, "R1 dac_code", int'(dac_code), 0);
    chk(mux_sel == '0, "R1 mux_sel", int'(mux_sel), 0);

    // R2: load codes, boundary values at both ends
    for (int c = 0; c < NC; c++) begin
      model[c] = (c * 37 + 5) % 256;
      if (c == 0)  model[c] = 8'h00;
      if (c == 31) model[c] = 8'hFF;
      mem_write(c, model[c]);
    end
    mem_write(32, 8'h5A);
    mem_write(35, 8'hC3);
    mem_write(127, 8'h77);

    // R4: clear, then run; R5 wrap over 40 steps
    ctrl_write(3'b100);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 40; i++) push_item(i % NC, (i == 0) ? D + 1 : D - 1);
    ctrl_write(3'b011);
    // R3: write while refreshing is discarded
    mem_write(3, 8'hAA);
    wait (pulses_done == 40);
    @(negedge clk);

    // R9: output enable low while counting
    ctrl_write(3'b010);
    expect_quiet(4 * D, "R9 out_en low");
    // R9: load mode
    ctrl_write(3'b000);
    expect_quiet(2 * D, "R9 count_en low");

    // R2: reload channel 3 in load mode; R4 clear from a nonzero channel
    mem_write(3, 8'hAA);
    model[3] = 8'hAA;
    ctrl_write(3'b100);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 6; i++) push_item(i, (i == 0) ? D + 1 : D - 1);
    ctrl_write(3'b011);
    wait (pulses_done == 46);
    @(negedge clk);
    ctrl_write(3'b000);
    expect_quiet(D, "R9 stop");

    chk(q.size() == 0, "R5 scoreboard drained", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule